// File: doc/BRIEF.md
# Branch History Table Predictor

This block predicts taken branches at instruction fetch for a 16-bit in-order pipeline. It keeps a small fully associative table in which each entry holds a branch address, the address that branch last jumped to, and a single history bit. Every cycle the fetch address is looked up. When it hits an entry whose history bit is set, the block tells the fetch unit to take the stored target as the next address. Otherwise the next address is the sequential one.

Later in the pipeline, a resolved branch-if-equal reports its address, its computed target and whether it was actually taken. If the branch is already in the table and the outcome disagrees with the stored history bit, the block overwrites that bit and raises a flush. On this correction it redirects to the instruction after the branch when the branch was not taken. A taken correction is left to the pipeline's own branch path. A branch that is not yet in the table gets an entry, with round-robin replacement. Jump-and-link instructions use the same table, with their outcome forced to taken, so that later executions of the same jump are redirected at fetch and lose no cycle.

Lookup and correction are combinational within the cycle. Table writes take effect at the next clock edge.

Top module: `branch_hist_predictor`

## Requirements
- R1: After reset every entry is invalid, so any fetch address gives redirect_en=0, flush=0 and redirect_pc = fetch_pc + 1.
- R2: When fetch_pc hits a valid entry whose history bit is 1 and no flush is raised, redirect_en=1 and redirect_pc is that entry's target, in the same cycle.
- R3: When fetch_pc misses, or hits an entry whose history bit is 0, and no flush is raised, redirect_en=0 and redirect_pc = fetch_pc + 1.
- R4: A resolve (res_valid=1) whose res_pc misses the table writes a new valid entry holding res_pc, res_target and the outcome as its history bit, visible to fetch from the next cycle. It raises no flush.
- R5: A resolve that hits an entry with a history bit different from the outcome raises flush in that cycle. It writes the outcome into the history bit, effective from the next cycle.
- R6: While flush is high, redirect_en equals the inverse of the outcome and redirect_pc = res_pc + 1. This overrides the fetch-side lookup.
- R7: A resolve that hits an entry whose history bit equals the outcome raises no flush and leaves the table unchanged.
- R8: The outcome is res_taken OR res_link, so a jump-and-link resolve (res_link=1) always counts as taken.
- R9: New entries are placed in slots 0,1,...,ENTRIES-1 in order, wrapping around. With 8 slots, the ninth distinct branch replaces the first one allocated.
- R10: With res_valid=0 the resolve inputs are ignored: no flush, and the table is unchanged.
- R11: The fetch lookup in a cycle that also carries a table write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 16 | Address being fetched this cycle |
| res_valid | input | 1 | A branch or jump-and-link resolves this cycle |
| res_link | input | 1 | The resolving instruction is a jump-and-link (forces taken) |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_pc | input | 16 | Address of the resolving branch |
| res_target | input | 16 | Target address of the resolving branch |
| redirect_en | output | 1 | Take redirect_pc as next fetch address |
| redirect_pc | output | 16 | Predicted target, correction address or sequential address |
| flush | output | 1 | Misprediction detected; flush and stall the front end |

## Verification
A corrupted history bit shows up at the ports in the very next cycle that fetches the branch. redirect_en takes the wrong value, or a resolve that ought to agree raises flush instead. A lost or misplaced allocation shows up at the first fetch of that address after the resolve edge. A replacement pointer that steps wrongly shows up only when the table wraps, as the wrong branch losing its prediction. The bench therefore fills the table past its depth and then fetches both the evicted address and a surviving one.

// File: rtl/bhp_pkg.sv
`timescale 1ns/1ps
package bhp_pkg;
    localparam int PC_W = 16;

    typedef logic [PC_W-1:0] pc_t;

    typedef struct packed {
        logic vld;
        logic hist;
        pc_t  br_pc;
        pc_t  tgt_pc;
    } bhp_entry_t;
endpackage

// File: rtl/bhp_lookup.sv
`timescale 1ns/1ps
module bhp_lookup #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  bhp_pkg::bhp_entry_t [ENTRIES-1:0] tbl,
    input  bhp_pkg::pc_t                      key,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx
);
    // lowest matching slot wins; allocation only on miss keeps matches unique
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tbl[i].vld && (tbl[i].br_pc == key)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bhp_rr_ptr.sv
`timescale 1ns/1ps
module bhp_rr_ptr #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/branch_hist_predictor.sv
`timescale 1ns/1ps
module branch_hist_predictor #(
    parameter int ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          fetch_pc,
    input  logic                 res_valid,
    input  logic                 res_link,
    input  logic                 res_taken,
    input  logic [15:0]          res_pc,
    input  logic [15:0]          res_target,
    output logic                 redirect_en,
    output logic [15:0]          redirect_pc,
    output logic                 flush
);
    import bhp_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        bhp_entry_t [ENTRIES-1:0] tbl;
    } state_t;

    state_t st_d, st_q;

    logic             f_hit, r_hit;
    logic [IDX_W-1:0] f_idx, r_idx, alloc_idx;
    logic             outcome, mispredict, alloc;

    // fetch-side and resolve-side searches share one matcher design
    bhp_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_fetch_lu (
        .tbl (st_q.tbl),
        .key (fetch_pc),
        .hit (f_hit),
        .idx (f_idx)
    );

    bhp_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_res_lu (
        .tbl (st_q.tbl),
        .key (res_pc),
        .hit (r_hit),
        .idx (r_idx)
    );

    bhp_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (alloc),
        .ptr   (alloc_idx)
    );

    // jump-and-link always resolves as taken
    assign outcome    = res_taken | res_link;
    assign mispredict = res_valid && r_hit && (st_q.tbl[r_idx].hist != outcome);
    assign alloc      = res_valid && !r_hit;

    always_comb begin
        st_d = st_q;
        if (mispredict) begin
            st_d.tbl[r_idx].hist = outcome;
        end else if (alloc) begin
            st_d.tbl[alloc_idx].vld    = 1'b1;
            st_d.tbl[alloc_idx].hist   = outcome;
            st_d.tbl[alloc_idx].br_pc  = res_pc;
            st_d.tbl[alloc_idx].tgt_pc = res_target;
        end
    end

    // resolve correction outranks the fetch prediction
    always_comb begin
        flush       = 1'b0;
        redirect_en = 1'b0;
        redirect_pc = fetch_pc + 1'b1;
        if (mispredict) begin
            flush       = 1'b1;
            redirect_en = !outcome;
            redirect_pc = res_pc + 1'b1;
        end else if (f_hit && st_q.tbl[f_idx].hist) begin
            redirect_en = 1'b1;
            redirect_pc = st_q.tbl[f_idx].tgt_pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bhp_checker.sv
`timescale 1ns/1ps
module bhp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] fetch_pc,
    input logic        res_valid,
    input logic        res_link,
    input logic        res_taken,
    input logic [15:0] res_pc,
    input logic [15:0] res_target,
    input logic        redirect_en,
    input logic [15:0] redirect_pc,
    input logic        flush
);
    logic [15:0] res_next, fetch_next;
    assign res_next   = res_pc + 16'd1;
    assign fetch_next = fetch_pc + 16'd1;

    // R6
    flush_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> redirect_pc == res_next);

    // R6
    flush_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> redirect_en == !(res_taken || res_link));

    // R10
    idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !flush);

    // R3
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_en && !flush) |-> redirect_pc == fetch_next);

    // R1
    post_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!redirect_en && !flush));

    // R5
    repeat_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(flush) && res_pc == $past(res_pc)
         && (res_taken || res_link) == $past(res_taken || res_link)) |-> !flush);
endmodule

bind branch_hist_predictor bhp_checker u_chk (.*);

// File: tb/branch_hist_predictor_bench.sv
`timescale 1ns/1ps
module branch_hist_predictor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        res_valid = 1'b0;
    logic        res_link = 1'b0;
    logic        res_taken = 1'b0;
    logic [15:0] res_pc = '0;
    logic [15:0] res_target = '0;
    logic        redirect_en;
    logic [15:0] redirect_pc;
    logic        flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    branch_hist_predictor u_branch_hist_predictor (.*);

    typedef struct packed {
        logic        rv;
        logic        rl;
        logic        rt;
        logic [15:0] rpc;
        logic [15:0] rtg;
        logic [15:0] fpc;
        logic        een;
        logic [15:0] epc;
        logic        efl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0010,1'b0,16'h0011,1'b0,8'd1},  // R1 cold miss
        '{1'b1,1'b0,1'b1,16'h0010,16'h0040,16'h0010,1'b0,16'h0011,1'b0,8'd11}, // R4 R11 alloc, old view
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0010,1'b1,16'h0040,1'b0,8'd2},  // R2 predicted taken
        '{1'b1,1'b0,1'b1,16'h0010,16'h0040,16'h0010,1'b1,16'h0040,1'b0,8'd7},  // R7 agreeing resolve
        '{1'b1,1'b0,1'b0,16'h0010,16'h0040,16'h0010,1'b1,16'h0011,1'b1,8'd6},  // R6 not-taken correction
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0010,1'b0,16'h0011,1'b0,8'd5},  // R5 history now 0
        '{1'b1,1'b0,1'b1,16'h0010,16'h0040,16'h0022,1'b0,16'h0011,1'b1,8'd6},  // R6 taken correction
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0010,1'b1,16'h0040,1'b0,8'd5},  // R5 history back to 1
        '{1'b1,1'b1,1'b0,16'h0030,16'h0050,16'h0030,1'b0,16'h0031,1'b0,8'd8},  // R8 link alloc
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0030,1'b1,16'h0050,1'b0,8'd8},  // R8 link predicted
        '{1'b1,1'b1,1'b0,16'h0030,16'h0050,16'h0055,1'b0,16'h0056,1'b0,8'd8},  // R8 link agrees
        '{1'b0,1'b0,1'b0,16'h0010,16'h0040,16'h0010,1'b1,16'h0040,1'b0,8'd10}, // R10 ignored resolve
        '{1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0010,1'b1,16'h0040,1'b0,8'd10}  // R10 table unchanged
    };

    task automatic chk(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic rv, input logic rl, input logic rt,
                         input logic [15:0] rpc, input logic [15:0] rtg,
                         input logic [15:0] fpc);
        res_valid  = rv;
        res_link   = rl;
        res_taken  = rt;
        res_pc     = rpc;
        res_target = rtg;
        fetch_pc   = fpc;
    endtask

    task automatic expect_out(input int req, input logic een,
                              input logic [15:0] epc, input logic efl);
        @(negedge clk);
        chk(req, "redirect_en", {15'd0, redirect_en}, {15'd0, een});
        chk(req, "redirect_pc", redirect_pc, epc);
        chk(req, "flush", {15'd0, flush}, {15'd0, efl});
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].rv, VECS[v].rl, VECS[v].rt, VECS[v].rpc, VECS[v].rtg, VECS[v].fpc);
            expect_out(int'(VECS[v].req), VECS[v].een, VECS[v].epc, VECS[v].efl);
        end

        // R9: slots 0 and 1 are used; fill 2..7, then wrap to slot 0
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b0, 1'b1, 16'h0100 + 16'(i), 16'h0200 + 16'(i), 16'hAAAA);
            expect_out(4, 1'b0, 16'hAAAB, 1'b0);
        end
        drive(1'b1, 1'b0, 1'b1, 16'h0106, 16'h0206, 16'hAAAA);
        expect_out(9, 1'b0, 16'hAAAB, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0010);
        expect_out(9, 1'b0, 16'h0011, 1'b0);   // R9 first entry evicted
        drive(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0030);
        expect_out(9, 1'b1, 16'h0050, 1'b0);   // R9 second entry kept
        drive(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0106);
        expect_out(9, 1'b1, 16'h0206, 1'b0);   // R9 newcomer present
        drive(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0105);
        expect_out(2, 1'b1, 16'h0205, 1'b0);   // R2 last slot

        // R1: reset clears a populated table
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0030);
        expect_out(1, 1'b0, 16'h0031, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'hFFFF);
        expect_out(3, 1'b0, 16'h0000, 1'b0);   // R3 sequential wrap

        finish_run();
    end
endmodule